// File: doc/BRIEF.md
# Streaming Cell Histogram Accumulator

This block takes a raster stream of per-pixel gradient votes and turns it into orientation histograms for square cells. Each vote is a magnitude and a bin code. Each cell is `CELL_PX` × `CELL_PX` pixels and each histogram has nine bins. A frame is `CELLS_X` cells wide. With the default parameters that is 100 cells of 8 pixels, an 800-pixel line. Every pixel adds its whole magnitude to exactly one bin of its own cell. There is no interpolation between neighbouring bins or cells.

Votes for one cell width are collected in a small bank of local bin registers. When the last pixel of that cell width on the current line arrives, the nine partial sums are written in one go to one slot of a line-partial store. That store holds one slot per cell for each pixel line of a cell row. On the final pixel line of a cell row, the fresh partial is added to the stored partials of that cell to form the whole-cell histogram. The result goes into a two-row cell store.

Once a frame has at least two complete cell rows, each finished cell is presented together with the cell directly above it. A following block-normalisation stage can then assemble overlapping 2×2 blocks. Frame-start and line-start flags on a pixel realign the position counters.

Top module: `cell_hist_accum`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `pair_valid` is 0 and both `pair_upper` and `pair_lower` are all zeros.
- R2: A pixel with bin code 0..8 adds its magnitude to that bin of its own cell. A bin code of 9..15 casts no vote, but the pixel still advances the position by one.
- R3: On the clock edge that takes the bottom-right pixel of a cell, the whole-cell histogram (the sum of all its pixel votes) appears on `pair_lower` with `pair_valid` = 1. Bin k occupies bits [k*13 +: 13], and `pair_col` gives the cell column (0 at the left).
- R4: In the same cycle, `pair_upper` carries the histogram of the cell in the same column one cell row higher in the same frame, with the same bin layout.
- R5: No pair is presented for cell row 0 of a frame. `pair_row` gives the cell row of `pair_lower`, and `pair_valid` is a single-cycle pulse. A frame of N cell rows yields exactly (N-1)·`CELLS_X` pairs, in raster order.
- R6: Each bin of a whole-cell histogram saturates at 8191 instead of wrapping.
- R7: Cycles with `pix_valid` low are ignored: they neither vote nor advance the position, and the results match an unbroken stream.
- R8: A pixel with `frame_start` = 1 is pixel (0,0) of a new frame. All partial work of the previous frame is discarded, and no pair is presented in the following cycle.
- R9: A pixel with `line_start` = 1 is column 0 of the current line. The votes collected so far on that line are replaced when the line is sent again, and the line count is not advanced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid | input | 1 | Pixel vote present this cycle |
| pix_mag | input | 9 | Gradient magnitude of the pixel |
| pix_bin | input | 4 | Orientation bin code (0..8 vote) |
| frame_start | input | 1 | Pixel is the first of a frame |
| line_start | input | 1 | Pixel is the first of a line |
| pair_valid | output | 1 | Cell pair present (one-cycle pulse) |
| pair_col | output | $clog2(CELLS_X) | Cell column of the pair |
| pair_row | output | ROW_W | Cell row of the lower cell |
| pair_upper | output | 117 | Nine 13-bit bins of the upper cell |
| pair_lower | output | 117 | Nine 13-bit bins of the lower cell |

## Verification
The critical coincidence happens on the bottom-right pixel of a cell. On that edge the pixel's own vote is folded in and the local partial is flushed. The same edge also sums that fresh partial with the seven stored partials and emits the pair. The bench streams frames with no gaps, so every closing pixel carries a random vote that must show up in the emitted histogram. A second coincidence is a frame or line restart arriving on a pixel that also votes. Both are judged by comparing every bin of every pair with sums that the bench computes from its own copy of the frame.

// File: rtl/chist_pkg.sv
package chist_pkg;
    parameter int NBINS    = 9;
    parameter int BIN_W    = 4;
    parameter int MAG_W    = 9;
    parameter int PART_W   = 12;
    parameter int CELL_W   = 13;
    parameter int CELL_MAX = (1 << CELL_W) - 1;

    typedef logic [NBINS-1:0][PART_W-1:0] part_vec_t;
    typedef logic [NBINS-1:0][CELL_W-1:0] cell_vec_t;
endpackage

// File: rtl/chist_vote.sv
module chist_vote
    import chist_pkg::*;
(
    input  part_vec_t           base_i,
    input  logic                valid_i,
    input  logic [MAG_W-1:0]    mag_i,
    input  logic [BIN_W-1:0]    bin_i,
    output part_vec_t           part_o
);
    for (genvar k = 0; k < NBINS; k++) begin : g_bin
        logic [PART_W:0] sum;
        logic            hit;
        assign hit = valid_i && (bin_i == BIN_W'(k));
        assign sum = {1'b0, base_i[k]} + (hit ? (PART_W+1)'(mag_i) : '0);
        assign part_o[k] = sum[PART_W] ? {PART_W{1'b1}} : sum[PART_W-1:0];
    end
endmodule

// File: rtl/chist_part_store.sv
module chist_part_store
    import chist_pkg::*;
#(
    parameter int CELLS_X = 100,
    parameter int LINES   = 8,
    localparam int CW = $clog2(CELLS_X),
    localparam int LW = $clog2(LINES)
) (
    input  logic                    clk,
    input  logic                    we_i,
    input  logic [LW-1:0]           wline_i,
    input  logic [CW-1:0]           wcol_i,
    input  part_vec_t               wdata_i,
    input  logic [CW-1:0]           rcol_i,
    output part_vec_t [LINES-1:0]   rdata_o
);
    part_vec_t mem [LINES][CELLS_X];

    always_ff @(posedge clk) begin
        if (we_i) mem[wline_i][wcol_i] <= wdata_i;
    end

    for (genvar l = 0; l < LINES; l++) begin : g_rd
        assign rdata_o[l] = mem[l][rcol_i];
    end
endmodule

// File: rtl/chist_cell_sum.sv
module chist_cell_sum
    import chist_pkg::*;
#(
    parameter int LINES = 8,
    localparam int SUM_W = PART_W + $clog2(LINES) + 1
) (
    input  part_vec_t [LINES-1:0]   lines_i,
    output cell_vec_t               cell_o
);
    for (genvar k = 0; k < NBINS; k++) begin : g_bin
        always_comb begin
            logic [SUM_W-1:0] tot;
            tot = '0;
            for (int l = 0; l < LINES; l++) begin
                tot = tot + SUM_W'(lines_i[l][k]);
            end
            cell_o[k] = (tot > SUM_W'(CELL_MAX)) ? CELL_W'(CELL_MAX) : tot[CELL_W-1:0];
        end
    end
endmodule

// File: rtl/chist_cell_store.sv
module chist_cell_store
    import chist_pkg::*;
#(
    parameter int CELLS_X = 100,
    localparam int CW = $clog2(CELLS_X)
) (
    input  logic            clk,
    input  logic            we_i,
    input  logic            wrow_i,
    input  logic [CW-1:0]   col_i,
    input  cell_vec_t       wdata_i,
    input  logic            rrow_i,
    output cell_vec_t       rdata_o
);
    cell_vec_t mem [2][CELLS_X];

    always_ff @(posedge clk) begin
        if (we_i) mem[wrow_i][col_i] <= wdata_i;
    end

    assign rdata_o = mem[rrow_i][col_i];
endmodule

// File: rtl/cell_hist_accum.sv
module cell_hist_accum
    import chist_pkg::*;
#(
    parameter int CELLS_X = 100,
    parameter int CELL_PX = 8,
    parameter int ROW_W   = 8,
    localparam int CX_W  = $clog2(CELLS_X),
    localparam int PX_W  = $clog2(CELL_PX),
    localparam int VEC_W = NBINS * CELL_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pix_valid,
    input  logic [MAG_W-1:0]    pix_mag,
    input  logic [BIN_W-1:0]    pix_bin,
    input  logic                frame_start,
    input  logic                line_start,
    output logic                pair_valid,
    output logic [CX_W-1:0]     pair_col,
    output logic [ROW_W-1:0]    pair_row,
    output logic [VEC_W-1:0]    pair_upper,
    output logic [VEC_W-1:0]    pair_lower
);
    typedef struct packed {
        logic [PX_W-1:0]    px;
        logic [CX_W-1:0]    cx;
        logic [PX_W-1:0]    line;
        logic [ROW_W-1:0]   crow;
        part_vec_t          acc;
        logic               pv;
        logic [CX_W-1:0]    ocol;
        logic [ROW_W-1:0]   orow;
        cell_vec_t          up;
        cell_vec_t          lo;
    } state_t;

    state_t st_q, st_d;

    // position of the current pixel after any restart flag is applied
    logic               sof, sol;
    logic [PX_W-1:0]    eff_px, eff_line;
    logic [CX_W-1:0]    eff_cx;
    logic [ROW_W-1:0]   eff_crow;
    logic               flush, end_line, last_line, sum_now;
    part_vec_t          acc_base, part_next;
    part_vec_t [CELL_PX-1:0] stored, sum_in;
    cell_vec_t          cell_sum, upper_rd;

    assign sof      = pix_valid && frame_start;
    assign sol      = pix_valid && (frame_start || line_start);
    assign eff_px   = sol ? '0 : st_q.px;
    assign eff_cx   = sol ? '0 : st_q.cx;
    assign eff_line = sof ? '0 : st_q.line;
    assign eff_crow = sof ? '0 : st_q.crow;
    assign acc_base = (eff_px == '0) ? '0 : st_q.acc;

    assign flush     = pix_valid && (eff_px == PX_W'(CELL_PX-1));
    assign end_line  = flush && (eff_cx == CX_W'(CELLS_X-1));
    assign last_line = (eff_line == PX_W'(CELL_PX-1));
    assign sum_now   = flush && last_line;

    chist_vote u_vote (
        .base_i  (acc_base),
        .valid_i (pix_valid),
        .mag_i   (pix_mag),
        .bin_i   (pix_bin),
        .part_o  (part_next)
    );

    chist_part_store #(.CELLS_X(CELLS_X), .LINES(CELL_PX)) u_part (
        .clk     (clk),
        .we_i    (flush),
        .wline_i (eff_line),
        .wcol_i  (eff_cx),
        .wdata_i (part_next),
        .rcol_i  (eff_cx),
        .rdata_o (stored)
    );

    // the newest line is taken straight from the voter, not from the store
    for (genvar l = 0; l < CELL_PX; l++) begin : g_sum_in
        if (l == CELL_PX - 1) begin : g_fresh
            assign sum_in[l] = part_next;
        end else begin : g_kept
            assign sum_in[l] = stored[l];
        end
    end

    chist_cell_sum #(.LINES(CELL_PX)) u_sum (
        .lines_i (sum_in),
        .cell_o  (cell_sum)
    );

    chist_cell_store #(.CELLS_X(CELLS_X)) u_cells (
        .clk     (clk),
        .we_i    (sum_now),
        .wrow_i  (eff_crow[0]),
        .col_i   (eff_cx),
        .wdata_i (cell_sum),
        .rrow_i  (~eff_crow[0]),
        .rdata_o (upper_rd)
    );

    always_comb begin
        st_d    = st_q;
        st_d.pv = 1'b0;
        if (pix_valid) begin
            st_d.acc  = part_next;
            st_d.px   = flush ? '0 : eff_px + PX_W'(1);
            st_d.cx   = flush ? (end_line ? '0 : eff_cx + CX_W'(1)) : eff_cx;
            st_d.line = end_line ? (last_line ? '0 : eff_line + PX_W'(1)) : eff_line;
            st_d.crow = (end_line && last_line) ? eff_crow + ROW_W'(1) : eff_crow;
            if (sum_now && (eff_crow != '0)) begin
                st_d.pv   = 1'b1;
                st_d.ocol = eff_cx;
                st_d.orow = eff_crow;
                st_d.up   = upper_rd;
                st_d.lo   = cell_sum;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pair_valid = st_q.pv;
    assign pair_col   = st_q.ocol;
    assign pair_row   = st_q.orow;
    assign pair_upper = st_q.up;
    assign pair_lower = st_q.lo;
endmodule

// File: rtl/cell_hist_accum_checker.sv
module cell_hist_accum_checker #(
    parameter int CELLS_X = 100,
    parameter int ROW_W   = 8,
    localparam int CX_W = $clog2(CELLS_X)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pix_valid,
    input logic             frame_start,
    input logic             pair_valid,
    input logic [CX_W-1:0]  pair_col,
    input logic [ROW_W-1:0] pair_row
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> !pair_valid);

    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid |=> !pair_valid);

    assert_not_first_row_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid |-> (pair_row != '0));

    assert_col_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid |-> (int'(pair_col) < CELLS_X));

    assert_needs_pixel_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid |-> $past(pix_valid));

    assert_restart_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && frame_start) |=> !pair_valid);
endmodule

bind cell_hist_accum cell_hist_accum_checker #(.CELLS_X(CELLS_X), .ROW_W(ROW_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pix_valid   (pix_valid),
    .frame_start (frame_start),
    .pair_valid  (pair_valid),
    .pair_col    (pair_col),
    .pair_row    (pair_row)
);

// File: tb/cell_hist_accum_bench.sv
module cell_hist_accum_bench;
    import chist_pkg::*;

    localparam int CX = 4, CP = 8, RW = 4, NROWS = 4;
    localparam int W = CX * CP, H = NROWS * CP, NPAIR = (NROWS - 1) * CX;
    localparam int VW = NBINS * CELL_W;
    // each row: mode, seed, expected pair count
    localparam int TBL [5][3] = '{
        '{0, 32'h1234_5677, NPAIR},
        '{1, 32'h0BAD_F00D, NPAIR},
        '{2, 32'h2468_ACE1, NPAIR},
        '{3, 32'h1357_9BDF, NPAIR},
        '{4, 32'h7777_1111, NPAIR}
    };

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n, pix_valid, frame_start, line_start;
    logic [MAG_W-1:0] pix_mag;
    logic [BIN_W-1:0] pix_bin;
    logic pair_valid;
    logic [$clog2(CX)-1:0] pair_col;
    logic [RW-1:0] pair_row;
    logic [VW-1:0] pair_upper, pair_lower;

    cell_hist_accum #(.CELLS_X(CX), .CELL_PX(CP), .ROW_W(RW)) u_cell_hist_accum (
        .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_mag(pix_mag),
        .pix_bin(pix_bin), .frame_start(frame_start), .line_start(line_start),
        .pair_valid(pair_valid), .pair_col(pair_col), .pair_row(pair_row),
        .pair_upper(pair_upper), .pair_lower(pair_lower)
    );

    int checks = 0, errors = 0;
    int f_mag [H][W];
    int f_bin [H][W];
    int hist [NROWS][CX][NBINS];
    int idx = 0;
    bit expect_none = 1'b0;
    bit prev_pv = 1'b0;
    string tag = "R3";
    logic [31:0] rng = 32'h1;

    function automatic logic [31:0] nxt(logic [31:0] s);
        logic [31:0] t;
        t = s ^ (s << 13);
        t = t ^ (t >> 17);
        t = t ^ (t << 5);
        return t;
    endfunction

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic build(int mode, int seed);
        rng = seed;
        for (int y = 0; y < H; y++)
            for (int x = 0; x < W; x++) begin
                rng = nxt(rng);
                case (mode)
                    1:       begin f_mag[y][x] = 511; f_bin[y][x] = 5; end
                    2:       begin f_mag[y][x] = int'(rng[12:4]); f_bin[y][x] = int'(rng[3:0]); end
                    default: begin f_mag[y][x] = int'(rng[16:8]); f_bin[y][x] = int'(rng[7:0]) % 9; end
                endcase
            end
        for (int r = 0; r < NROWS; r++)
            for (int c = 0; c < CX; c++)
                for (int k = 0; k < NBINS; k++) hist[r][c][k] = 0;
        for (int y = 0; y < H; y++)
            for (int x = 0; x < W; x++)
                if (f_bin[y][x] < NBINS)
                    hist[y/CP][x/CP][f_bin[y][x]] += f_mag[y][x];
        for (int r = 0; r < NROWS; r++)
            for (int c = 0; c < CX; c++)
                for (int k = 0; k < NBINS; k++)
                    if (hist[r][c][k] > CELL_MAX) hist[r][c][k] = CELL_MAX;
    endtask

    task automatic drive_pix(int m, int b, bit sf, bit sl);
        @(negedge clk);
        pix_valid = 1'b1; pix_mag = MAG_W'(m); pix_bin = BIN_W'(b);
        frame_start = sf; line_start = sl;
    endtask

    task automatic idle();
        @(negedge clk);
        pix_valid = 1'b0; frame_start = 1'b0; line_start = 1'b0;
        pix_mag = '0; pix_bin = '0;
    endtask

    task automatic send_frame(int mode, int nlines);
        for (int y = 0; y < nlines; y++) begin
            if (mode == 4 && y == 3) begin
                // partial line later replaced (R9)
                for (int j = 0; j < 5; j++) begin
                    rng = nxt(rng);
                    drive_pix(int'(rng[8:0]), int'(rng[15:12]) % 9, 1'b0, j == 0);
                end
            end
            for (int x = 0; x < W; x++) begin
                if (mode == 3) begin
                    rng = nxt(rng);
                    repeat (int'(rng[1:0]) % 3) idle();
                end
                drive_pix(f_mag[y][x], f_bin[y][x], (y == 0 && x == 0), x == 0);
            end
        end
        idle();
    endtask

    // pair monitor, sampled mid-cycle
    always @(negedge clk) begin
        if (rst_n) begin
            if (pair_valid && prev_pv)
                chk(1'b0, "R5", "pulse longer than one cycle", 2, 1);
            if (pair_valid) begin
                if (expect_none || idx >= NPAIR) begin
                    chk(1'b0, "R8", "unexpected pair", idx, -1);
                end else begin
                    int r, c;
                    r = idx / CX + 1;
                    c = idx % CX;
                    chk(int'(pair_row) == r, "R5", "pair row", pair_row, r);
                    chk(int'(pair_col) == c, "R3", "pair col", pair_col, c);
                    for (int k = 0; k < NBINS; k++) begin
                        chk(int'(pair_lower[k*CELL_W +: CELL_W]) == hist[r][c][k], tag,
                            "lower bin", pair_lower[k*CELL_W +: CELL_W], hist[r][c][k]);
                        chk(int'(pair_upper[k*CELL_W +: CELL_W]) == hist[r-1][c][k], "R4",
                            "upper bin", pair_upper[k*CELL_W +: CELL_W], hist[r-1][c][k]);
                    end
                    idx++;
                end
            end
            prev_pv = pair_valid;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; pix_valid = 1'b0; frame_start = 1'b0; line_start = 1'b0;
        pix_mag = '0; pix_bin = '0;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(pair_valid == 1'b0, "R1", "pair_valid in reset", pair_valid, 0);
        chk(pair_upper == '0, "R1", "upper in reset", pair_upper, 0);
        chk(pair_lower == '0, "R1", "lower in reset", pair_lower, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pair_valid == 1'b0, "R1", "pair_valid after reset", pair_valid, 0);

        for (int t = 0; t < 5; t++) begin
            case (TBL[t][0])
                1: tag = "R6";
                2: tag = "R2";
                3: tag = "R7";
                4: tag = "R9";
                default: tag = "R3";
            endcase
            build(TBL[t][0], TBL[t][1]);
            idx = 0;
            send_frame(TBL[t][0], H);
            repeat (4) idle();
            chk(idx == TBL[t][2], "R5", "pairs per frame", idx, TBL[t][2]);
        end

        // R8: abandoned frame, then a fresh one
        tag = "R8";
        expect_none = 1'b1;
        build(0, 32'h5A5A_1234);
        idx = 0;
        send_frame(0, 12);
        chk(idx == 0, "R8", "pairs from abandoned frame", idx, 0);
        expect_none = 1'b0;
        build(0, 32'h0F0F_3C3C);
        send_frame(0, H);
        repeat (4) idle();
        chk(idx == NPAIR, "R8", "pairs after restart", idx, NPAIR);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule